// File: doc/BRIEF.md
# Keyed Flash Command Controller

This block is the register front end for an on-chip flash array. A simple memory-mapped bus reaches it, with a word address, write data, a write strobe, a read strobe and read data. It holds an address register and a data register for the next flash operation. It also has a command register that starts a word program, a page erase or a full-array erase. A command is accepted only when the upper half of the same written word carries a 16-bit unlock key.

A started command keeps its bit set for the whole operation. A stub model of the array counts out a fixed busy time for each kind of operation. When that time ends, the bit clears itself and a raw completion flag rises, so software can either poll the command register or wait for the interrupt. An interrupt mask gates the raw flag onto the interrupt output. A masked-status register shows the gated flag, and writing a one to it clears the flag. Two protection words and a microsecond reload word are stored and read back only.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, the registers at 0x000, 0x004, 0x008, 0x00C, 0x010 and 0x014 read as zero. The read-protection word at 0x020 reads 0x800000FF, the program-protection word at 0x024 reads 0x000000FF, and the reload word at 0x028 reads 0x00000018.
- R2: The words at 0x000, 0x004, 0x020, 0x024 and 0x028 store all 32 written bits and read them back. The mask at 0x010 keeps only bit 0. The raw status at 0x00C ignores writes.
- R3: A write to 0x008 starts a command only when bits [31:16] equal 0xA442 and exactly one of bits [2:0] is set. Bit 0 selects program, bit 1 selects page erase and bit 2 selects mass erase. From the cycle after the write, 0x008 reads back the accepted bit in [2:0], and at most one command bit is ever set.
- R4: An accepted bit stays set for PROG_CYCLES, PAGE_CYCLES or MASS_CYCLES clock edges, counted from the write edge (defaults 16, 64 and 256). The bit then clears itself.
- R5: A command write whose bits [31:16] differ from the key sets no bit and starts no operation.
- R6: Command writes made while an operation is in progress are ignored, and the running command continues unchanged.
- R7: A keyed command write with none or more than one of bits [2:0] set is ignored.
- R8: On the edge where a command clears, raw status bit 0 at 0x00C becomes 1. Register 0x014 reads raw AND mask, and irqOut equals that masked bit.
- R9: Writing a 1 to bit 0 of 0x014 clears raw bit 0. Writing a 0 leaves it unchanged.
- R10: Reads of any offset not listed above return zero, and writes to such offsets change no register.
- R11: busRdata is zero whenever busRd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busWr | input | 1 | Write strobe, one word per cycle |
| busRd | input | 1 | Read strobe, data returned in the same cycle |
| busRdata | output | 32 | Read data, zero when not reading |
| irqOut | output | 1 | Masked completion interrupt |

## Verification
The properties assume that busAddr, busWdata and the strobes hold known values once reset is released. They also assume that a command write is judged on the value present at the clock edge, which is the only point where the controller samples it. The stimulus keeps to this by changing the inputs only on the falling edge and by raising at most one strobe per access. Read data is combinational, so the bench samples it shortly after it sets the read address. It also counts busy cycles by polling on falling edges, so every expected count is a plain number of rising edges since the write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_ADDR  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CMD   = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_PROTR = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_PROTP = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_USEC  = 12'h028;

  localparam logic [DATA_W-1:0] PROTR_RST = 32'h8000_00FF;
  localparam logic [DATA_W-1:0] PROTP_RST = 32'h0000_00FF;
  localparam logic [DATA_W-1:0] USEC_RST  = 32'h0000_0018;

  localparam int CMD_N = 3;

  // Strobes from the command sequencer to the register datapath
  typedef struct packed {
    logic [CMD_N-1:0] cmdLive;
    logic             opDone;
  } seqStrobe_t;
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int          PROG_CYCLES = 16,
  parameter int          PAGE_CYCLES = 64,
  parameter int          MASS_CYCLES = 256,
  parameter logic [15:0] CMD_KEY     = 16'hA442
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [15:0]       cmdKey,
  input  logic [CMD_N-1:0]  cmdReq,
  output seqStrobe_t        strobe
);
  localparam int MAX_A   = (PROG_CYCLES > PAGE_CYCLES) ? PROG_CYCLES : PAGE_CYCLES;
  localparam int MAX_CYC = (MAX_A > MASS_CYCLES) ? MAX_A : MASS_CYCLES;
  localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] PROG_LOAD = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] PAGE_LOAD = CNT_W'(PAGE_CYCLES - 1);
  localparam logic [CNT_W-1:0] MASS_LOAD = CNT_W'(MASS_CYCLES - 1);

  logic [CMD_N-1:0] liveQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] loadVal;
  logic             busy;
  logic             accept;
  logic             lastCycle;

  assign busy      = |liveQ;
  assign accept    = busWr && (busAddr == OFS_CMD) && (cmdKey == CMD_KEY)
                     && $onehot(cmdReq) && !busy;
  assign lastCycle = busy && (cntQ == '0);

  always_comb begin
    unique case (cmdReq)
      3'b001:  loadVal = PROG_LOAD;
      3'b010:  loadVal = PAGE_LOAD;
      default: loadVal = MASS_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveQ <= '0;
      cntQ  <= '0;
    end else if (accept) begin
      liveQ <= cmdReq;
      cntQ  <= loadVal;
    end else if (lastCycle) begin
      liveQ <= '0;
    end else if (busy) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  assign strobe.cmdLive = liveQ;
  assign strobe.opDone  = lastCycle;
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWr,
  input  logic              busRd,
  input  seqStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  logic [DATA_W-1:0] addrQ, dataQ, protRdQ, protPgQ, usecQ;
  logic              maskQ, rawQ;
  logic [DATA_W-1:0] readMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      maskQ   <= 1'b0;
      protRdQ <= PROTR_RST;
      protPgQ <= PROTP_RST;
      usecQ   <= USEC_RST;
    end else if (busWr) begin
      unique case (busAddr)
        OFS_ADDR:  addrQ   <= busWdata;
        OFS_DATA:  dataQ   <= busWdata;
        OFS_MASK:  maskQ   <= busWdata[0];
        OFS_PROTR: protRdQ <= busWdata;
        OFS_PROTP: protPgQ <= busWdata;
        OFS_USEC:  usecQ   <= busWdata;
        default: ;
      endcase
    end
  end

  // Completion set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                                rawQ <= 1'b0;
    else if (strobe.opDone)                                   rawQ <= 1'b1;
    else if (busWr && busAddr == OFS_CLR && busWdata[0])      rawQ <= 1'b0;
  end

  always_comb begin
    unique case (busAddr)
      OFS_ADDR:  readMux = addrQ;
      OFS_DATA:  readMux = dataQ;
      OFS_CMD:   readMux = {{(DATA_W-CMD_N){1'b0}}, strobe.cmdLive};
      OFS_RAW:   readMux = {{(DATA_W-1){1'b0}}, rawQ};
      OFS_MASK:  readMux = {{(DATA_W-1){1'b0}}, maskQ};
      OFS_CLR:   readMux = {{(DATA_W-1){1'b0}}, rawQ & maskQ};
      OFS_PROTR: readMux = protRdQ;
      OFS_PROTP: readMux = protPgQ;
      OFS_USEC:  readMux = usecQ;
      default:   readMux = '0;
    endcase
  end

  assign busRdata = busRd ? readMux : '0;
  assign irqOut   = rawQ & maskQ;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          PROG_CYCLES = 16,
  parameter int          PAGE_CYCLES = 64,
  parameter int          MASS_CYCLES = 256,
  parameter logic [15:0] CMD_KEY     = 16'hA442
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] busAddr,
  input  logic [31:0] busWdata,
  input  logic        busWr,
  input  logic        busRd,
  output logic [31:0] busRdata,
  output logic        irqOut
);
  seqStrobe_t strobes;

  flash_cmd_seq #(
    .PROG_CYCLES(PROG_CYCLES),
    .PAGE_CYCLES(PAGE_CYCLES),
    .MASS_CYCLES(MASS_CYCLES),
    .CMD_KEY    (CMD_KEY)
  ) uSeq (
    .clk    (clk),
    .rstN   (rstN),
    .busAddr(busAddr),
    .busWr  (busWr),
    .cmdKey (busWdata[31:16]),
    .cmdReq (busWdata[CMD_N-1:0]),
    .strobe (strobes)
  );

  flash_cmd_regs uRegs (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busWr   (busWr),
    .busRd   (busRd),
    .strobe  (strobes),
    .busRdata(busRdata),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/flash_cmd_ctrl_checker.sv
module flash_cmd_ctrl_checker
  import flash_cmd_pkg::*;
#(
  parameter logic [15:0] CMD_KEY = 16'hA442
) (
  input logic        clk,
  input logic        rstN,
  input logic [11:0] busAddr,
  input logic [31:0] busWdata,
  input logic        busWr,
  input logic        busRd,
  input logic [31:0] busRdata,
  input logic [2:0]  cmdLive,
  input logic        opDone
);
  logic cmdWr, keyOk, idle, knownOfs;
  assign cmdWr    = busWr && busAddr == OFS_CMD;
  assign keyOk    = busWdata[31:16] == CMD_KEY;
  assign idle     = cmdLive == 3'b000;
  assign knownOfs = busAddr inside {OFS_ADDR, OFS_DATA, OFS_CMD, OFS_RAW, OFS_MASK,
                                    OFS_CLR, OFS_PROTR, OFS_PROTP, OFS_USEC};

  a_r3_single_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdLive));

  a_r3_accept: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && keyOk && $onehot(busWdata[2:0]) && idle) |=> cmdLive == $past(busWdata[2:0]));

  a_r4_clear_on_done: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> idle);

  a_r5_bad_key: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !keyOk && idle) |=> idle);

  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!idle && !opDone) |=> $stable(cmdLive));

  a_r7_bad_bits: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && keyOk && !$onehot(busWdata[2:0]) && idle) |=> idle);

  a_r10_hole_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !knownOfs) |-> busRdata == 32'h0);

  a_r11_idle_bus_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> busRdata == 32'h0);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_checker #(.CMD_KEY(CMD_KEY)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busWr   (busWr),
  .busRd   (busRd),
  .busRdata(busRdata),
  .cmdLive (strobes.cmdLive),
  .opDone  (strobes.opDone)
);

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
  localparam int PROG = 16;
  localparam int PAGE = 64;
  localparam int MASS = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.PROG_CYCLES(PROG), .PAGE_CYCLES(PAGE), .MASS_CYCLES(MASS)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRd(busRd), .busRdata(busRdata), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        isWr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // R2 storage and read-only raw status, R10 holes
  localparam vec_t VECS [0:15] = '{
    '{1'b1, 12'h000, 32'h1234_5678, 32'h0, 4'd2},
    '{1'b0, 12'h000, 32'h0,         32'h1234_5678, 4'd2},
    '{1'b1, 12'h004, 32'hDEAD_BEEF, 32'h0, 4'd2},
    '{1'b0, 12'h004, 32'h0,         32'hDEAD_BEEF, 4'd2},
    '{1'b1, 12'h010, 32'hFFFF_FFFF, 32'h0, 4'd2},
    '{1'b0, 12'h010, 32'h0,         32'h0000_0001, 4'd2},
    '{1'b1, 12'h00C, 32'hFFFF_FFFF, 32'h0, 4'd2},
    '{1'b0, 12'h00C, 32'h0,         32'h0, 4'd2},
    '{1'b1, 12'h020, 32'h0,         32'h0, 4'd2},
    '{1'b0, 12'h020, 32'h0,         32'h0, 4'd2},
    '{1'b1, 12'h024, 32'hA5A5_A5A5, 32'h0, 4'd2},
    '{1'b0, 12'h024, 32'h0,         32'hA5A5_A5A5, 4'd2},
    '{1'b1, 12'h028, 32'h0000_0030, 32'h0, 4'd2},
    '{1'b0, 12'h028, 32'h0,         32'h0000_0030, 4'd2},
    '{1'b1, 12'h03C, 32'hFFFF_FFFF, 32'h0, 4'd10},
    '{1'b0, 12'h03C, 32'h0,         32'h0, 4'd10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rdNow(input logic [11:0] a, output logic [31:0] v);
    busAddr = a; busRd = 1'b1;
    #1 v = busRdata;
    busRd = 1'b0;
  endtask

  task automatic pollCount(output int n);
    logic [31:0] v;
    n = 0;
    rdNow(12'h008, v);
    while (v[2:0] != 3'b000 && n < 2000) begin
      n++;
      @(negedge clk);
      rdNow(12'h008, v);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    rdNow(12'h000, v); check("R1 addr", v, 32'h0);
    rdNow(12'h004, v); check("R1 data", v, 32'h0);
    rdNow(12'h008, v); check("R1 cmd", v, 32'h0);
    rdNow(12'h00C, v); check("R1 raw", v, 32'h0);
    rdNow(12'h010, v); check("R1 mask", v, 32'h0);
    rdNow(12'h014, v); check("R1 masked", v, 32'h0);
    rdNow(12'h020, v); check("R1 protRd", v, 32'h8000_00FF);
    rdNow(12'h024, v); check("R1 protPg", v, 32'h0000_00FF);
    rdNow(12'h028, v); check("R1 usec", v, 32'h0000_0018);
    // R11 no read strobe
    busAddr = 12'h020; #1 check("R11 idle bus", busRdata, 32'h0);

    foreach (VECS[i]) begin
      if (VECS[i].isWr) wr(VECS[i].addr, VECS[i].data);
      else begin
        @(negedge clk);
        rdNow(VECS[i].addr, v);
        check($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].exp);
      end
    end
    // R10 hole write leaves neighbours intact
    wr(12'h018, 32'hFFFF_FFFF);
    rdNow(12'h018, v); check("R10 hole read", v, 32'h0);
    rdNow(12'h014, v); check("R10 masked untouched", v, 32'h0);

    // R3 R4 program, mask=1
    wr(12'h008, 32'hA442_0001);
    rdNow(12'h008, v); check("R3 program bit", v, 32'h1);
    pollCount(n); check("R4 program cycles", n, PROG);
    rdNow(12'h00C, v); check("R8 raw set", v, 32'h1);
    rdNow(12'h014, v); check("R8 masked", v, 32'h1);
    check("R8 irq high", {31'h0, irqOut}, 32'h1);
    wr(12'h014, 32'h0);
    rdNow(12'h00C, v); check("R9 zero write keeps", v, 32'h1);
    wr(12'h014, 32'h1);
    rdNow(12'h00C, v); check("R9 clear", v, 32'h0);
    check("R9 irq low", {31'h0, irqOut}, 32'h0);

    // R4 page erase with mask off
    wr(12'h010, 32'h0);
    wr(12'h008, 32'hA442_0002);
    rdNow(12'h008, v); check("R3 page bit", v, 32'h2);
    pollCount(n); check("R4 page cycles", n, PAGE);
    rdNow(12'h00C, v); check("R8 raw set unmasked", v, 32'h1);
    rdNow(12'h014, v); check("R8 masked off", v, 32'h0);
    check("R8 irq gated", {31'h0, irqOut}, 32'h0);
    wr(12'h014, 32'h1);
    wr(12'h010, 32'h1);

    // R5 wrong key
    wr(12'h008, 32'hA441_0004);
    rdNow(12'h008, v); check("R5 bad key cmd", v, 32'h0);
    repeat (MASS + 4) @(negedge clk);
    rdNow(12'h00C, v); check("R5 no completion", v, 32'h0);

    // R7 zero or several bits
    wr(12'h008, 32'hA442_0003);
    rdNow(12'h008, v); check("R7 two bits", v, 32'h0);
    wr(12'h008, 32'hA442_0000);
    rdNow(12'h008, v); check("R7 no bits", v, 32'h0);
    repeat (PROG + 4) @(negedge clk);
    rdNow(12'h00C, v); check("R7 no completion", v, 32'h0);

    // R6 write while busy, mass erase
    wr(12'h008, 32'hA442_0004);
    wr(12'h008, 32'hA442_0001);
    rdNow(12'h008, v); check("R6 busy keeps mass", v, 32'h4);
    pollCount(n); check("R4 mass cycles", n, MASS - 2);
    check("R8 irq after mass", {31'h0, irqOut}, 32'h1);
    @(negedge clk);
    rdNow(12'h008, v); check("R6 no late start", v, 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule